// File: doc/BRIEF.md
# STN Panel Dot Packer

This block sits between a frame-buffer pixel stream and the data pins of a passive-matrix (STN) panel. Each incoming pixel becomes one or three on/off dots. A 2-bit gray pixel is looked up in a programmable table of four 4-bit levels. A 4-bit gray pixel is used as its own level. An RGB332 color pixel is split into red, green and blue dots. Every level is then reduced to a single dot by frame-rate modulation against a 4-bit frame counter. The counter advances on a frame pulse from the timing generator.

Dots collect in a small buffer for each lane. On each pixel-clock strobe from the timing generator, the block pulls out as many dots as its lane is wide and registers them onto an 8-bit data bus. There are three packings. In 4-bit single scan, one stream drives the low nibble. In 8-bit single scan, one stream drives the whole byte. In 4-bit dual scan, an upper-half stream and a lower-half stream drive the two nibbles on the same strobe. Both input streams use a valid/ready handshake.

Top module: `stn_dot_packer`

## Requirements
- R1: `scan_mode` 01 selects 4-bit single scan. Each strobe places 4 upper-stream dots on `vd[3:0]`, and `vd[7:4]` is 0.
- R2: `scan_mode` 00 selects 4-bit dual scan. On the same strobe, upper-stream dots go to `vd[3:0]` and lower-stream dots go to `vd[7:4]`.
- R3: `scan_mode` 10 selects 8-bit single scan. Each strobe places 8 upper-stream dots on `vd[7:0]`.
- R4: Within a lane, the oldest dot lands on the lane's highest bit (bit 3 of a nibble lane, bit 7 of the byte lane). A color pixel yields its dots in the order red, green, blue.
- R5: With `pix_fmt` 00 (2-bit gray), pixel bits [1:0] = n select the level `gray_lut[4n+3:4n]`. Pixel bits [7:2] are ignored.
- R6: With `pix_fmt` 01 (4-bit gray), pixel bits [3:0] are the level itself. With `pix_fmt` 11, every pixel gives one off dot.
- R7: With `pix_fmt` 10 (color), a pixel holds red in [7:5], green in [4:2] and blue in [1:0]. It yields three dots. Red and green are widened to 4 bits as {v, v[2]} and blue as {v, v}.
- R8: A dot is on exactly when its 4-bit level is greater than the frame count. The count resets to 0, adds one per `frame_tick` cycle and wraps from 15 to 0. The level is taken when the pixel is accepted.
- R9: `scan_mode` 11 is reserved. Neither stream is ready, and every strobe drives `vd` to 0.
- R10: `lo_ready` is low in every mode except dual scan.
- R11: `vd` changes only in a cycle with `dot_stb` high. If a lane holds fewer dots than its width at a strobe, it outputs zeros for that strobe and keeps its dots.
- R12: Each lane buffers up to 11 dots. A stream is ready only while its buffered count plus the dots of one pixel (1 gray, 3 color) is at most 11.
- R13: After reset, `vd` is 0, both buffers are empty and the frame count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_mode | input | 2 | Bus packing: 00 dual 4-bit, 01 single 4-bit, 10 single 8-bit, 11 reserved |
| pix_fmt | input | 2 | Pixel format: 00 gray2 via table, 01 gray4, 10 RGB332, 11 off |
| gray_lut | input | 16 | Four 4-bit levels for 2-bit gray pixels |
| frame_tick | input | 1 | Frame pulse; advances the modulation count |
| dot_stb | input | 1 | Pixel-clock strobe from the timing generator |
| up_valid | input | 1 | Upper/single stream pixel valid |
| up_pix | input | 8 | Upper/single stream pixel |
| up_ready | output | 1 | Upper/single stream ready |
| lo_valid | input | 1 | Lower-half stream pixel valid |
| lo_pix | input | 8 | Lower-half stream pixel |
| lo_ready | output | 1 | Lower-half stream ready |
| vd | output | 8 | Panel data bus |

## Verification
The bench checks the boundary of the modulation compare by setting the level equal to the frame count and one above it. A design that used >= would light dots it should leave dark. It checks dot order with mixed pixels, and color dots that straddle strobes. A reversed lane or a wrong R/G/B order would give mirrored nibbles. It drives an underrun and then refills the lane. A design that dropped the partial dots, or pushed out stale data, would show a wrong byte once the lane is full. It also probes the 11-dot capacity with color pixels and checks that upper pixel bits are ignored in table mode. It covers the wrap of the frame counter and the reserved mode, where a design that kept accepting pixels or drove the bus would show it.

// File: rtl/stn_dot_packer.sv
module stn_dot_packer #(
  parameter int CAP = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  scan_mode,
  input  logic [1:0]  pix_fmt,
  input  logic [15:0] gray_lut,
  input  logic        frame_tick,
  input  logic        dot_stb,
  input  logic        up_valid,
  input  logic [7:0]  up_pix,
  output logic        up_ready,
  input  logic        lo_valid,
  input  logic [7:0]  lo_pix,
  output logic        lo_ready,
  output logic [7:0]  vd
);
  localparam int CW = $clog2(CAP + 4);

  logic [3:0] fcnt;
  logic       dual, wide, rsvd;

  assign dual = (scan_mode == 2'b00);
  assign wide = (scan_mode == 2'b10);
  assign rsvd = (scan_mode == 2'b11);

  always_ff @(posedge clk)
    if (!rst_n) fcnt <= '0;
    else        fcnt <= fcnt + 4'(frame_tick);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0]     pix;
    logic           vld, en, rdy, take, acc;
    logic [CW-1:0]  cnt, need, k, base;
    logic [CAP-1:0] dbuf, shifted;
    logic [2:0]     d;
    logic [7:0]     lane_out;

    assign pix  = (g == 1) ? lo_pix : up_pix;
    assign vld  = (g == 1) ? lo_valid : up_valid;
    assign en   = (g == 1) ? dual : !rsvd;
    assign need = (g == 0 && wide) ? CW'(8) : CW'(4);

    always_comb begin
      d = '0;
      k = CW'(1);
      case (pix_fmt)
        2'b00: d[0] = gray_lut[{pix[1:0], 2'b00} +: 4] > fcnt;
        2'b01: d[0] = pix[3:0] > fcnt;
        2'b10: begin
          d[0] = {pix[7:5], pix[7]} > fcnt;
          d[1] = {pix[4:2], pix[4]} > fcnt;
          d[2] = {pix[1:0], pix[1:0]} > fcnt;
          k    = CW'(3);
        end
        default: d = '0;
      endcase
    end

    assign rdy     = en && (cnt + k <= CW'(CAP));
    assign acc     = vld && rdy;
    assign take    = dot_stb && en && (cnt >= need);
    assign base    = take ? cnt - need : cnt;
    assign shifted = take ? dbuf >> need : dbuf;

    always_ff @(posedge clk)
      if (!rst_n) begin
        cnt  <= '0;
        dbuf <= '0;
      end else begin
        cnt  <= base + (acc ? k : CW'(0));
        dbuf <= acc ? (shifted | (CAP'(d) << base)) : shifted;
      end

    always_comb
      for (int i = 0; i < 8; i++) lane_out[7-i] = dbuf[i];

    p_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CAP));
  end

  assign up_ready = g_lane[0].rdy;
  assign lo_ready = g_lane[1].rdy;

  always_ff @(posedge clk)
    if (!rst_n) vd <= '0;
    else if (dot_stb) begin
      if (rsvd)      vd <= '0;
      else if (wide) vd <= g_lane[0].take ? g_lane[0].lane_out : 8'h00;
      else           vd <= {g_lane[1].take ? g_lane[1].lane_out[7:4] : 4'h0,
                            g_lane[0].take ? g_lane[0].lane_out[7:4] : 4'h0};
    end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_stb |=> $stable(vd));
  p_rsvd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 2'b11) |-> (!up_ready && !lo_ready));
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 2'b11 && dot_stb) |=> (vd == 8'h00));
  p_lo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode != 2'b00) |-> !lo_ready);
  p_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == 2'b01 && dot_stb) |=> (vd[7:4] == 4'h0));
endmodule

// File: tb/stn_dot_packer_test.sv
`timescale 1ns/1ps
module stn_dot_packer_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] scan_mode = 2'b01, pix_fmt = 2'b01;
  logic [15:0] gray_lut = 16'hF930;
  logic frame_tick = 0, dot_stb = 0;
  logic up_valid = 0, lo_valid = 0;
  logic [7:0] up_pix = 0, lo_pix = 0;
  logic up_ready, lo_ready;
  logic [7:0] vd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stn_dot_packer uut (.clk, .rst_n, .scan_mode, .pix_fmt, .gray_lut, .frame_tick,
    .dot_stb, .up_valid, .up_pix, .up_ready, .lo_valid, .lo_pix, .lo_ready, .vd);

  // {scan, fmt, lut, frames, up_pix, lo_pix, expected vd, req}
  localparam int NV = 22;
  localparam logic [55:0] VEC [NV] = '{
    {2'b01, 2'b01, 16'hF930, 4'd0,  8'h05, 8'h00, 8'h0F, 8'd1},  // R1 on
    {2'b01, 2'b01, 16'hF930, 4'd5,  8'h05, 8'h00, 8'h00, 8'd8},  // R8 equal -> off
    {2'b01, 2'b01, 16'hF930, 4'd4,  8'h05, 8'h00, 8'h0F, 8'd8},  // R8 above -> on
    {2'b10, 2'b01, 16'hF930, 4'd14, 8'h0F, 8'h00, 8'hFF, 8'd3},  // R3
    {2'b10, 2'b01, 16'hF930, 4'd15, 8'h0F, 8'h00, 8'h00, 8'd8},  // R8 level 15 at count 15
    {2'b00, 2'b01, 16'hF930, 4'd3,  8'h08, 8'h02, 8'h0F, 8'd2},  // R2 upper only
    {2'b00, 2'b01, 16'hF930, 4'd3,  8'h01, 8'h0C, 8'hF0, 8'd2},  // R2 lower only
    {2'b01, 2'b00, 16'hF930, 4'd2,  8'h01, 8'h00, 8'h0F, 8'd5},  // R5 nibble1=3
    {2'b01, 2'b00, 16'hF930, 4'd3,  8'h01, 8'h00, 8'h00, 8'd5},  // R5
    {2'b01, 2'b00, 16'hF930, 4'd8,  8'hFE, 8'h00, 8'h0F, 8'd5},  // R5 upper bits ignored
    {2'b01, 2'b00, 16'hF930, 4'd0,  8'h00, 8'h00, 8'h00, 8'd5},  // R5 nibble0=0
    {2'b01, 2'b10, 16'hF930, 4'd7,  8'hE0, 8'h00, 8'h09, 8'd7},  // R7 red
    {2'b01, 2'b10, 16'hF930, 4'd7,  8'h1C, 8'h00, 8'h04, 8'd7},  // R7 green
    {2'b01, 2'b10, 16'hF930, 4'd7,  8'h03, 8'h00, 8'h02, 8'd7},  // R7 blue
    {2'b10, 2'b10, 16'hF930, 4'd7,  8'h83, 8'h00, 8'hB6, 8'd4},  // R4 RGB order over 8
    {2'b01, 2'b10, 16'hF930, 4'd5,  8'h60, 8'h00, 8'h09, 8'd7},  // R7 red 011 -> 6
    {2'b01, 2'b10, 16'hF930, 4'd6,  8'h60, 8'h00, 8'h00, 8'd7},
    {2'b01, 2'b10, 16'hF930, 4'd4,  8'h01, 8'h00, 8'h02, 8'd7},  // R7 blue 01 -> 5
    {2'b01, 2'b10, 16'hF930, 4'd5,  8'h01, 8'h00, 8'h00, 8'd7},
    {2'b11, 2'b01, 16'hF930, 4'd0,  8'h0F, 8'h0F, 8'h00, 8'd9},  // R9 reserved
    {2'b10, 2'b11, 16'hF930, 4'd0,  8'hFF, 8'h00, 8'h00, 8'd6},  // R6 fmt 11
    {2'b00, 2'b10, 16'hF930, 4'd7,  8'hE0, 8'h03, 8'h29, 8'd2}   // R2 dual color
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] sm, input logic [1:0] pf);
    @(negedge clk);
    rst_n = 0; scan_mode = sm; pix_fmt = pf;
    up_valid = 0; lo_valid = 0; dot_stb = 0; frame_tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input logic [7:0] u, input logic [7:0] l, input int n);
    up_pix = u; lo_pix = l; up_valid = 1; lo_valid = 1;
    repeat (n) @(negedge clk);
    up_valid = 0; lo_valid = 0;
  endtask

  task automatic strobe;
    dot_stb = 1;
    @(negedge clk);
    dot_stb = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin frame_tick = 1; @(negedge clk); end
    frame_tick = 0;
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][55:54], VEC[i][53:52]);
      gray_lut = VEC[i][51:36];
      ticks(int'(VEC[i][35:32]));
      push(VEC[i][31:24], VEC[i][23:16], 14);
      strobe();
      check(vd, VEC[i][15:8], int'(VEC[i][7:0]), $sformatf("vector %0d", i));
    end

    // R13 reset state, R10 lower stream idle outside dual
    restart(2'b01, 2'b01);
    check(vd, 8'h00, 13, "vd after reset");
    check({7'b0, up_ready}, 8'h01, 13, "up_ready after reset");
    check({7'b0, lo_ready}, 8'h00, 10, "lo_ready single scan");
    strobe();
    check(vd, 8'h00, 13, "strobe with empty buffers");
    restart(2'b00, 2'b01);
    check({7'b0, lo_ready}, 8'h01, 10, "lo_ready dual scan");

    // R4 oldest dot on the highest lane bit
    restart(2'b01, 2'b01);
    push(8'h05, 8'h00, 2);
    push(8'h00, 8'h00, 2);
    strobe();
    check(vd, 8'h0C, 4, "order 5,5,0,0");

    // R11 underrun keeps dots, bus held between strobes
    restart(2'b10, 2'b01);
    push(8'h0F, 8'h00, 5);
    strobe();
    check(vd, 8'h00, 11, "underrun zero");
    push(8'h0F, 8'h00, 3);
    strobe();
    check(vd, 8'hFF, 11, "refill after underrun");
    push(8'h00, 8'h00, 5);
    check(vd, 8'hFF, 11, "hold without strobe");

    // R12 capacity with color pixels
    restart(2'b01, 2'b10);
    ticks(7);
    push(8'hE0, 8'h00, 14);
    check({7'b0, up_ready}, 8'h00, 12, "full at 9 dots");
    strobe();
    check(vd, 8'h09, 12, "strobe from full lane");
    check({7'b0, up_ready}, 8'h01, 12, "ready at 5 dots");

    // R12 gray fill stops at 11 dots
    restart(2'b01, 2'b01);
    push(8'h0F, 8'h00, 10);
    check({7'b0, up_ready}, 8'h01, 12, "ready at 10 dots");
    push(8'h0F, 8'h00, 1);
    check({7'b0, up_ready}, 8'h00, 12, "full at 11 dots");

    // R8 frame count wraps after 16 ticks
    restart(2'b01, 2'b01);
    ticks(16);
    push(8'h01, 8'h00, 4);
    strobe();
    check(vd, 8'h0F, 8, "count wrap");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule